// File: doc/BRIEF.md
# Duplicated State Rollback Controller

This block guards a small sequential datapath against upsets by running it twice. Two copies of the state register, each with its own next-state logic, step together. Their registered values are compared every cycle. A third register keeps the most recent state on which both copies agreed. When the copies disagree, the block reloads both of them from that saved state in a single cycle. While it does so, the output shows the saved state and a rollback flag is raised.

The protected datapath here is a Galois LFSR with a step enable. It stands in for any small controller. One mask input per copy XORs into the value that copy loads at the next edge, so a bench can upset single bits or hold a fault in place.

Back-to-back rollbacks mean the fault does not clear by itself. After a parameterised number of consecutive rollback cycles, a sticky reconfiguration request goes high. Only reset clears it.

Top module: `dup_rollback_ctrl`

## Requirements
- R1: While reset is low and after it is released, `state_o` equals the seed (default 8'h01), and `rollback_o` and `reconfig_req_o` are 0.
- R2: Without faults and with `step_en` high, the state advances every cycle by the rule next = (s << 1) XOR (s[W-1] ? TAPS : 0), with TAPS default 8'h1D. With `step_en` low, the state holds.
- R3: `rollback_o` is 1 in exactly those cycles in which the two registered copies differ.
- R4: In a rollback cycle, `state_o` shows the saved state, which is the last state on which both copies agreed.
- R5: At the edge that ends a rollback cycle, both copies load the saved state, so the datapath restarts from it.
- R6: The saved state takes the agreed value only at the end of a cycle with no mismatch. In a rollback cycle it is left unchanged.
- R7: A count of consecutive rollback cycles clears on any cycle with no mismatch. `reconfig_req_o` rises in the cycle after the N-th consecutive rollback cycle (N default 2). Isolated single rollbacks never raise it.
- R8: Once `reconfig_req_o` is high, it stays high until reset.
- R9: `inject_main` and `inject_repl` XOR bit by bit into the value the main copy or the replica loads at the next edge. This also applies to a load from the saved state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| step_en | input | 1 | Advances the protected LFSR |
| inject_main | input | W | Bit-flip mask applied to the main copy's next load |
| inject_repl | input | W | Bit-flip mask applied to the replica's next load |
| state_o | output | W | Protected state: the main copy, or the saved state during rollback |
| rollback_o | output | 1 | High in cycles where the copies disagree and are being restored |
| reconfig_req_o | output | 1 | Sticky request raised by repeated consecutive rollbacks |

## Verification
The sweep upsets every bit of the main copy, and then every bit of the replica, with the LFSR both stepping and held. This shows that a fault is detected and repaired whichever copy takes it. It also shows that the output never exposes the corrupted value. Separate isolated upsets confirm that single events never escalate. A two-cycle burst and a fault held on the replica each drive the rollback count to its limit. The burst separates a fault that merely repeats from one that persists across a reload. A reset in the middle of the run then shows that the request is sticky until reset and is cleared by it.

// File: rtl/rollback_pkg.sv
package rollback_pkg;
  localparam int unsigned NUM_COPIES = 2;
  typedef enum int unsigned {
    COPY_MAIN = 0,
    COPY_REPL = 1
  } copy_e;
endpackage

// File: rtl/state_copy.sv
module state_copy #(
  parameter int unsigned W     = 8,
  parameter logic [31:0] TAPS  = 32'h1D,
  parameter logic [31:0] SEED  = 32'h01
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step_en_i,
  input  logic         restore_i,
  input  logic [W-1:0] saved_i,
  input  logic [W-1:0] flip_i,
  output logic [W-1:0] state_q
);
  localparam logic [W-1:0] TAP_MASK  = TAPS[W-1:0];
  localparam logic [W-1:0] SEED_VAL  = SEED[W-1:0];

  logic [W-1:0] stepped;
  logic [W-1:0] state_d;

  always_comb begin
    stepped = state_q;
    if (step_en_i) begin
      stepped = {state_q[W-2:0], 1'b0} ^ (state_q[W-1] ? TAP_MASK : '0);
    end
    state_d = (restore_i ? saved_i : stepped) ^ flip_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEED_VAL;
    end else begin
      state_q <= state_d;
    end
  end
endmodule

// File: rtl/rollback_escalator.sv
module rollback_escalator #(
  parameter int unsigned N = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rollback_i,
  output logic reconfig_o
);
  localparam int unsigned CW = $clog2(N + 1);
  localparam logic [CW-1:0] LIMIT    = CW'(N);
  localparam logic [CW-1:0] LIMIT_M1 = CW'(N - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          reconf_q, reconf_d;

  always_comb begin
    cnt_d    = '0;
    reconf_d = reconf_q;
    if (rollback_i) begin
      cnt_d = (cnt_q == LIMIT) ? LIMIT : cnt_q + 1'b1;
      if (cnt_q >= LIMIT_M1) begin
        reconf_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      reconf_q <= 1'b0;
    end else begin
      cnt_q    <= cnt_d;
      reconf_q <= reconf_d;
    end
  end

  assign reconfig_o = reconf_q;

  // R7
  cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rollback_i |=> cnt_q == '0);

  // R7
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LIMIT);

  // R8
  reconf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reconf_q |=> reconf_q);
endmodule

// File: rtl/dup_rollback_ctrl.sv
module dup_rollback_ctrl
  import rollback_pkg::*;
#(
  parameter int unsigned W     = 8,
  parameter logic [31:0] TAPS  = 32'h1D,
  parameter logic [31:0] SEED  = 32'h01,
  parameter int unsigned N     = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step_en,
  input  logic [W-1:0] inject_main,
  input  logic [W-1:0] inject_repl,
  output logic [W-1:0] state_o,
  output logic         rollback_o,
  output logic         reconfig_req_o
);
  localparam logic [W-1:0] SEED_VAL = SEED[W-1:0];

  logic [NUM_COPIES-1:0][W-1:0] copy_q;
  logic [NUM_COPIES-1:0][W-1:0] flip;
  logic [W-1:0]                 hist_q, hist_d;
  logic                         mismatch;

  assign flip[COPY_MAIN] = inject_main;
  assign flip[COPY_REPL] = inject_repl;

  for (genvar c = 0; c < NUM_COPIES; c++) begin : g_copy
    state_copy #(
      .W    (W),
      .TAPS (TAPS),
      .SEED (SEED)
    ) u_copy (
      .clk       (clk),
      .rst_n     (rst_n),
      .step_en_i (step_en),
      .restore_i (mismatch),
      .saved_i   (hist_q),
      .flip_i    (flip[c]),
      .state_q   (copy_q[c])
    );
  end

  assign mismatch = (copy_q[COPY_MAIN] != copy_q[COPY_REPL]);

  always_comb begin
    hist_d = hist_q;
    if (!mismatch) begin
      hist_d = copy_q[COPY_MAIN];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q <= SEED_VAL;
    end else begin
      hist_q <= hist_d;
    end
  end

  rollback_escalator #(.N(N)) u_esc (
    .clk        (clk),
    .rst_n      (rst_n),
    .rollback_i (mismatch),
    .reconfig_o (reconfig_req_o)
  );

  assign rollback_o = mismatch;
  assign state_o    = mismatch ? hist_q : copy_q[COPY_MAIN];

  // R5
  restore_eq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rollback_o) && ($past(inject_main) == $past(inject_repl))
      |-> copy_q[COPY_MAIN] == copy_q[COPY_REPL]);

  // R5
  restore_val_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rollback_o) && ($past(inject_main) == '0)
      |-> copy_q[COPY_MAIN] == $past(hist_q));

  // R6
  hist_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rollback_o |=> $stable(hist_q));
endmodule

// File: tb/dup_rollback_ctrl_tb_top.sv
module dup_rollback_ctrl_tb_top;
  localparam int unsigned W          = 8;
  localparam int unsigned N          = 2;
  localparam logic [7:0]  TAPS       = 8'h1D;
  localparam logic [7:0]  SEED       = 8'h01;
  localparam int          CLK_PERIOD = 10;
  localparam int          WDOG_LIMIT = 20000;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         step_en;
  logic [W-1:0] inject_main, inject_repl;
  logic [W-1:0] state_o;
  logic         rollback_o, reconfig_req_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  // reference state, derived from the requirements
  logic [W-1:0] m_main, m_repl, m_hist;
  int           m_cnt;
  logic         m_req;
  logic         m_prev_rb;

  dup_rollback_ctrl #(.W(W), .TAPS(32'(TAPS)), .SEED(32'(SEED)), .N(N)) dut_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .step_en        (step_en),
    .inject_main    (inject_main),
    .inject_repl    (inject_repl),
    .state_o        (state_o),
    .rollback_o     (rollback_o),
    .reconfig_req_o (reconfig_req_o)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > WDOG_LIMIT) begin
      errors++;
      $display("FAIL watchdog: cycles %0d expected below %0d", cycles, WDOG_LIMIT);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  function automatic logic [W-1:0] lfsr(input logic [W-1:0] s);
    return {s[W-2:0], 1'b0} ^ (s[W-1] ? TAPS : 8'h00);
  endfunction

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    m_main = SEED; m_repl = SEED; m_hist = SEED;
    m_cnt = 0; m_req = 1'b0; m_prev_rb = 1'b0;
  endtask

  // compare outputs against the model (called at a falling edge)
  task automatic compare_outputs();
    logic mis;
    mis = (m_main != m_repl);
    // R3: flag follows disagreement of the copies
    check("R3", W'(rollback_o), W'(mis));
    if (mis)            check("R4", state_o, m_hist);
    else if (m_prev_rb) check("R5", state_o, m_main);
    else                check("R2", state_o, m_main);
    check(m_req ? "R8" : "R7", W'(reconfig_req_o), W'(m_req));
  endtask

  // one cycle: check, drive, advance model, wait for next falling edge
  task automatic cycle(input logic en, input logic [W-1:0] im, input logic [W-1:0] ir);
    logic mis;
    compare_outputs();
    step_en = en; inject_main = im; inject_repl = ir;
    mis = (m_main != m_repl);
    // R9: masks XOR into every load, including a restore from history
    if (mis) begin
      m_main = m_hist ^ im;
      m_repl = m_hist ^ ir;
      // R6: history untouched in a rollback cycle
      if (m_cnt >= N - 1) m_req = 1'b1;
      m_cnt = (m_cnt == N) ? N : m_cnt + 1;
    end else begin
      m_hist = m_main;
      m_main = (en ? lfsr(m_main) : m_main) ^ im;
      m_repl = (en ? lfsr(m_repl) : m_repl) ^ ir;
      m_cnt  = 0;
    end
    m_prev_rb = mis;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    step_en = 1'b0; inject_main = '0; inject_repl = '0;
    @(negedge clk);
    model_reset();
    // R1: values while reset is held
    check("R1", state_o, SEED);
    check("R1", W'(rollback_o), '0);
    check("R1", W'(reconfig_req_o), '0);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    do_reset();
    // R1: first cycle after release
    check("R1", state_o, SEED);

    // R2: clean stepping and holding
    for (int i = 0; i < 20; i++) cycle(1'b1, '0, '0);
    for (int i = 0; i < 4; i++)  cycle(1'b0, '0, '0);

    // single-bit upsets on every bit of each copy, stepping and held
    for (int en = 0; en < 2; en++) begin
      for (int cp = 0; cp < 2; cp++) begin
        for (int b = 0; b < W; b++) begin
          logic [W-1:0] msk;
          msk = W'(1) << b;
          cycle(1'(en), '0, '0);
          cycle(1'(en), cp == 0 ? msk : '0, cp == 1 ? msk : '0);
          for (int k = 0; k < 4; k++) cycle(1'(en), '0, '0);
        end
      end
    end
    // R7: isolated rollbacks never escalate
    check("R7", W'(reconfig_req_o), '0);

    // R7: burst of two upsets, second lands on the restore load
    cycle(1'b1, 8'h10, '0);
    cycle(1'b1, 8'h10, '0);
    for (int k = 0; k < 5; k++) cycle(1'b1, '0, '0);
    check("R7", W'(reconfig_req_o), 1);

    // R8: request stays high through clean cycles
    for (int k = 0; k < 6; k++) cycle(1'b1, '0, '0);
    check("R8", W'(reconfig_req_o), 1);

    // R1/R8: reset clears the request
    do_reset();
    check("R8", W'(reconfig_req_o), '0);

    // R9: fault held on the replica escalates
    for (int k = 0; k < 3; k++) cycle(1'b1, '0, '0);
    for (int k = 0; k < 5; k++) cycle(1'b1, '0, 8'h81);
    for (int k = 0; k < 3; k++) cycle(1'b1, '0, '0);
    check("R9", W'(reconfig_req_o), 1);

    do_reset();
    for (int k = 0; k < 4; k++) cycle(1'b1, '0, '0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule